// File: doc/BRIEF.md
# Bus Cycle Decoder with Wait-State Ready Control

This block sits on the target side of a 64-bit processor-style local bus. When the active-low address strobe is low at a rising clock edge, it captures three cycle-definition lines and a pair of cacheability hints. The three lines are memory-or-port, data-or-code and write-or-read. From these it selects one decoded, active-high strobe for the whole bus cycle: memory read, memory write, port read, port write, interrupt acknowledge or special cycle. Memory and port targets can be enabled directly from these strobes, with no decoding of their own.

The block also closes every transfer with the active-low burst-ready handshake. A read that both the processor and the target mark as cacheable becomes a four-beat line fill. Every other cycle is a single transfer. Before each beat, the controller holds ready high for a number of wait states taken from a 3-bit input, so slow targets can be served. An address strobe that arrives while a cycle is still open is flagged and otherwise dropped.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, brdyN is 1, burstCyc is 0, protoErr is 0 and all six decoded strobes are 0.
- R2: The cycle definition {memIo,dataCode,writeRead} is captured only at an edge where adsN is 0 and no cycle is open. 3'b000 asserts intAck. 3'b001 asserts specCyc. 3'b010 asserts ioRd. 3'b011 asserts ioWr. 3'b100 (code fetch) and 3'b110 assert memRd. 3'b111 asserts memWr. The definition lines and the cache hints have no effect at any other edge.
- R3: At most one decoded strobe is high at any time. It rises in the clock after the accepting edge and holds steady until the edge that samples the final brdyN low of the cycle.
- R4: A cycle is a four-beat burst (burstCyc high) only when memIo=1, writeRead=0, cacheOut=1 and cacheEn=1 at the accepting edge. Otherwise it has exactly one transfer.
- R5: Each beat loads waitStates (0 to 7) at its start edge. For the first beat this is the accepting edge; for later beats it is the edge that completes the previous beat. brdyN then stays high for that many clocks and is low for exactly one clock. Changes to waitStates in between have no effect.
- R6: After the final brdyN low the block is idle for at least one clock. In that clock all strobes are 0 and brdyN is 1. An address strobe in an idle clock is accepted.
- R7: adsN low at an edge where a cycle is open makes protoErr high for the following clock only. The open cycle continues unchanged.
- R8: beatNum gives the index of the current beat, from 0 to 3 in a burst and 0 in a single transfer. It is valid during the clock in which brdyN is low.
- R9: The reserved definition 3'b101 runs one transfer with the normal ready timing, and no decoded strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| adsN | input | 1 | Active-low address strobe, marks a cycle start |
| memIo | input | 1 | 1 = memory access, 0 = port access |
| dataCode | input | 1 | 1 = data, 0 = code |
| writeRead | input | 1 | 1 = write, 0 = read |
| cacheOut | input | 1 | Processor marks the read cacheable |
| cacheEn | input | 1 | Target accepts a line fill |
| waitStates | input | 3 | Wait states for the beat that is starting |
| brdyN | output | 1 | Active-low burst ready, closes a transfer |
| memRd | output | 1 | Memory read or code fetch strobe |
| memWr | output | 1 | Memory write strobe |
| ioRd | output | 1 | Port read strobe |
| ioWr | output | 1 | Port write strobe |
| intAck | output | 1 | Interrupt acknowledge strobe |
| specCyc | output | 1 | Special cycle strobe |
| burstCyc | output | 1 | Current cycle is a four-beat fill |
| beatNum | output | 2 | Index of the current beat |
| protoErr | output | 1 | One-clock flag for a strobe during an open cycle |

## Verification
Counting from the accepting edge, the decoded strobe and burstCyc are due one clock later. For beat b with w wait states, brdyN falls w clocks after that beat's start edge. protoErr follows the offending edge by one clock. The idle clock comes directly after the last ready. The bench steps a model timeline one falling edge at a time and compares every output against the value due in that clock. During open cycles and idle gaps it drives random values on the definition, cache and wait-state lines, to show that they are ignored there. Random cycles from a fixed seed are mixed with directed cases: all eight definitions, burst against single-transfer selection, seven wait states, changing wait counts between beats, and strobes that overlap a cycle, including one that lands on its final ready.

// File: rtl/busc_pkg.sv
package busc_pkg;

  // Cycle kinds, encoded as {memIo, dataCode, writeRead}
  typedef enum logic [2:0] {
    KIND_INTACK  = 3'b000,
    KIND_SPECIAL = 3'b001,
    KIND_IORD    = 3'b010,
    KIND_IOWR    = 3'b011,
    KIND_CODERD  = 3'b100,
    KIND_RESV    = 3'b101,
    KIND_MEMRD   = 3'b110,
    KIND_MEMWR   = 3'b111
  } cycKindT;

  // Control-to-datapath strobes
  typedef struct packed {
    logic start;     // cycle accepted this edge
    logic nextBeat;  // a non-final beat completes
    logic finish;    // the final beat completes
  } ctlStrobeT;

  typedef struct packed {
    logic memRd;
    logic memWr;
    logic ioRd;
    logic ioWr;
    logic intAck;
    logic specCyc;
  } strobeSetT;

  function automatic strobeSetT decodeKind(input cycKindT kind);
    strobeSetT s;
    s = '0;
    case (kind)
      KIND_INTACK:  s.intAck  = 1'b1;
      KIND_SPECIAL: s.specCyc = 1'b1;
      KIND_IORD:    s.ioRd    = 1'b1;
      KIND_IOWR:    s.ioWr    = 1'b1;
      KIND_CODERD:  s.memRd   = 1'b1;
      KIND_MEMRD:   s.memRd   = 1'b1;
      KIND_MEMWR:   s.memWr   = 1'b1;
      default:      s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/busc_ctrl.sv
module busc_ctrl
  import busc_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              adsN,
  input  logic [WAIT_W-1:0] waitStates,
  input  logic              lastBeat,
  output ctlStrobeT         ctl,
  output logic              busy,
  output logic              brdyN,
  output logic              protoErr
);

  typedef enum logic {ST_IDLE, ST_ACTIVE} stateT;

  stateT             state;
  logic [WAIT_W-1:0] waitCnt;
  logic              beatReady;

  assign busy      = (state == ST_ACTIVE);
  assign beatReady = busy && (waitCnt == '0);
  assign brdyN     = ~beatReady;

  always_comb begin
    ctl          = '0;
    ctl.start    = (state == ST_IDLE) && !adsN;
    ctl.nextBeat = beatReady && !lastBeat;
    ctl.finish   = beatReady && lastBeat;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      waitCnt  <= '0;
      protoErr <= 1'b0;
    end else begin
      protoErr <= busy && !adsN;
      case (state)
        ST_IDLE: begin
          if (ctl.start) begin
            state   <= ST_ACTIVE;
            waitCnt <= waitStates;
          end
        end
        ST_ACTIVE: begin
          if (ctl.finish) begin
            state <= ST_IDLE;
          end else if (ctl.nextBeat) begin
            waitCnt <= waitStates;
          end else begin
            waitCnt <= waitCnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/busc_datapath.sv
module busc_datapath
  import busc_pkg::*;
#(
  parameter int BURST_BEATS = 4,
  parameter int BEAT_W      = $clog2(BURST_BEATS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         ctl,
  input  logic              memIo,
  input  logic              dataCode,
  input  logic              writeRead,
  input  logic              cacheOut,
  input  logic              cacheEn,
  output strobeSetT         strobes,
  output logic              burstCyc,
  output logic [BEAT_W-1:0] beatNum,
  output logic              lastBeat
);

  localparam logic [BEAT_W-1:0] FINAL_BEAT = BEAT_W'(BURST_BEATS - 1);

  cycKindT kindIn;
  logic    fillReq;

  assign kindIn   = cycKindT'({memIo, dataCode, writeRead});
  assign fillReq  = memIo && !writeRead && cacheOut && cacheEn;
  assign lastBeat = !burstCyc || (beatNum == FINAL_BEAT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobes  <= '0;
      burstCyc <= 1'b0;
      beatNum  <= '0;
    end else if (ctl.start) begin
      strobes  <= decodeKind(kindIn);
      burstCyc <= fillReq;
      beatNum  <= '0;
    end else if (ctl.finish) begin
      strobes  <= '0;
      burstCyc <= 1'b0;
      beatNum  <= '0;
    end else if (ctl.nextBeat) begin
      beatNum <= beatNum + 1'b1;
    end
  end

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import busc_pkg::*;
#(
  parameter  int BURST_BEATS = 4,
  parameter  int WAIT_W      = 3,
  localparam int BEAT_W      = $clog2(BURST_BEATS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              adsN,
  input  logic              memIo,
  input  logic              dataCode,
  input  logic              writeRead,
  input  logic              cacheOut,
  input  logic              cacheEn,
  input  logic [WAIT_W-1:0] waitStates,
  output logic              brdyN,
  output logic              memRd,
  output logic              memWr,
  output logic              ioRd,
  output logic              ioWr,
  output logic              intAck,
  output logic              specCyc,
  output logic              burstCyc,
  output logic [BEAT_W-1:0] beatNum,
  output logic              protoErr
);

  ctlStrobeT ctl;
  strobeSetT strobes;
  logic      busy;
  logic      lastBeat;

  busc_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .adsN      (adsN),
    .waitStates(waitStates),
    .lastBeat  (lastBeat),
    .ctl       (ctl),
    .busy      (busy),
    .brdyN     (brdyN),
    .protoErr  (protoErr)
  );

  busc_datapath #(.BURST_BEATS(BURST_BEATS), .BEAT_W(BEAT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .memIo    (memIo),
    .dataCode (dataCode),
    .writeRead(writeRead),
    .cacheOut (cacheOut),
    .cacheEn  (cacheEn),
    .strobes  (strobes),
    .burstCyc (burstCyc),
    .beatNum  (beatNum),
    .lastBeat (lastBeat)
  );

  assign memRd   = strobes.memRd;
  assign memWr   = strobes.memWr;
  assign ioRd    = strobes.ioRd;
  assign ioWr    = strobes.ioWr;
  assign intAck  = strobes.intAck;
  assign specCyc = strobes.specCyc;

endmodule

// File: rtl/busc_checker.sv
module busc_checker #(
  parameter int BURST_BEATS = 4,
  parameter int BEAT_W      = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              adsN,
  input logic              busy,
  input logic              brdyN,
  input logic              protoErr,
  input logic              burstCyc,
  input logic [BEAT_W-1:0] beatNum,
  input logic [5:0]        strobeVec
);

  localparam logic [BEAT_W-1:0] FINAL_BEAT = BEAT_W'(BURST_BEATS - 1);

  // R3
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobeVec));

  // R3
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(strobeVec));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (strobeVec == 6'b0 && brdyN));

  // R6
  accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !adsN) |=> (busy && !protoErr));

  // R7
  proto_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !adsN) |=> protoErr);

  // R4
  single_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!burstCyc && !brdyN) |=> !busy);

  // R8
  beat_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (burstCyc && !brdyN && beatNum != FINAL_BEAT) |=>
      (busy && beatNum == $past(beatNum) + 1'b1));

endmodule

bind bus_cycle_ctrl busc_checker #(.BURST_BEATS(BURST_BEATS), .BEAT_W(BEAT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .adsN     (adsN),
  .busy     (busy),
  .brdyN    (brdyN),
  .protoErr (protoErr),
  .burstCyc (burstCyc),
  .beatNum  (beatNum),
  .strobeVec({memRd, memWr, ioRd, ioWr, intAck, specCyc})
);

// File: tb/bus_cycle_ctrl_test.sv
`timescale 1ns/1ps
module bus_cycle_ctrl_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       adsN = 1'b1;
  logic       memIo = 1'b0, dataCode = 1'b0, writeRead = 1'b0;
  logic       cacheOut = 1'b0, cacheEn = 1'b0;
  logic [2:0] waitStates = 3'd0;
  logic       brdyN, memRd, memWr, ioRd, ioWr, intAck, specCyc, burstCyc, protoErr;
  logic [1:0] beatNum;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  bus_cycle_ctrl uut (
    .clk(clk), .rstN(rstN), .adsN(adsN), .memIo(memIo), .dataCode(dataCode),
    .writeRead(writeRead), .cacheOut(cacheOut), .cacheEn(cacheEn),
    .waitStates(waitStates), .brdyN(brdyN), .memRd(memRd), .memWr(memWr),
    .ioRd(ioRd), .ioWr(ioWr), .intAck(intAck), .specCyc(specCyc),
    .burstCyc(burstCyc), .beatNum(beatNum), .protoErr(protoErr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] expStrobes(input bit m, input bit d, input bit w);
    case ({m, d, w})
      3'b000:  return 6'b000010;
      3'b001:  return 6'b000001;
      3'b010:  return 6'b001000;
      3'b011:  return 6'b000100;
      3'b100:  return 6'b100000;
      3'b110:  return 6'b100000;
      3'b111:  return 6'b010000;
      default: return 6'b000000;
    endcase
  endfunction

  function automatic logic [5:0] strobeNow();
    return {memRd, memWr, ioRd, ioWr, intAck, specCyc};
  endfunction

  task automatic scramble();
    memIo = 1'($urandom); dataCode = 1'($urandom); writeRead = 1'($urandom);
    cacheOut = 1'($urandom); cacheEn = 1'($urandom);
  endtask

  // Idle clocks with ADS high and noisy lines: nothing may happen (R2, R6)
  task automatic idleGap(input int n);
    for (int i = 0; i < n; i++) begin
      scramble();
      waitStates = 3'($urandom);
      @(negedge clk);
      check("R2 idle strobes", 32'(strobeNow()), 32'h0);
      check("R6 idle brdyN", 32'(brdyN), 32'h1);
    end
  endtask

  // Called just after a falling edge with the design idle
  task automatic runCycle(input bit m, input bit d, input bit w, input bit co,
                          input bit ce, input int ws0, input int wsN, input bit injErr);
    logic [5:0] exp;
    bit         burst;
    int         nb;
    int         s;
    exp   = expStrobes(m, d, w);
    burst = m && !w && co && ce;
    nb    = burst ? 4 : 1;
    adsN = 1'b0; memIo = m; dataCode = d; writeRead = w;
    cacheOut = co; cacheEn = ce; waitStates = 3'(ws0);
    @(negedge clk);
    adsN = injErr ? 1'b0 : 1'b1;
    scramble();
    s = 0;
    for (int b = 0; b < nb; b++) begin
      int wb;
      wb = (b == 0) ? ws0 : wsN;
      for (int k = 0; k <= wb; k++) begin
        if (s == 1) adsN = 1'b1;
        check((m && d == 0 && w) ? "R9 strobes" : "R2 R3 strobes", 32'(strobeNow()), 32'(exp));
        check("R4 burstCyc", 32'(burstCyc), 32'(burst));
        check("R7 protoErr", 32'(protoErr), 32'(injErr && s == 1));
        check("R5 brdyN", 32'(brdyN), (k == wb) ? 32'h0 : 32'h1);
        if (k == wb) begin
          check("R8 beatNum", 32'(beatNum), 32'(b));
          waitStates = 3'(wsN);
        end else begin
          waitStates = 3'($urandom);
        end
        scramble();
        s++;
        @(negedge clk);
      end
    end
    adsN = 1'b1;
    check("R6 end strobes", 32'(strobeNow()), 32'h0);
    check("R6 end brdyN", 32'(brdyN), 32'h1);
    check("R6 end burstCyc", 32'(burstCyc), 32'h0);
    check("R7 protoErr end", 32'(protoErr), 32'(injErr && s == 1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 brdyN", 32'(brdyN), 32'h1);
    check("R1 strobes", 32'(strobeNow()), 32'h0);
    check("R1 burstCyc", 32'(burstCyc), 32'h0);
    check("R1 protoErr", 32'(protoErr), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle brdyN", 32'(brdyN), 32'h1);
    check("R1 idle strobes", 32'(strobeNow()), 32'h0);

    // R2, R9: every definition, zero and nonzero waits
    for (int c = 0; c < 8; c++) begin
      runCycle(c[2], c[1], c[0], 1'b0, 1'b0, 0, 0, 1'b0);
      runCycle(c[2], c[1], c[0], 1'b0, 1'b0, c % 4 + 1, 0, 1'b0);
    end
    // R4: bursts on code and data reads, changing waits between beats (R5)
    runCycle(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 0, 0, 1'b0);
    runCycle(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 7, 2, 1'b0);
    runCycle(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 3, 7, 1'b0);
    // R4: only one of the two hints, or a write or a port read
    runCycle(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1, 0, 1'b0);
    runCycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1, 0, 1'b0);
    runCycle(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 0, 0, 1'b0);
    runCycle(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2, 0, 1'b0);
    // R7: strobe in an open cycle, also on the final ready
    runCycle(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4, 0, 1'b1);
    runCycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 1'b1);
    runCycle(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2, 1, 1'b1);
    // R6: back-to-back after one idle clock
    runCycle(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 0, 0, 1'b0);
    runCycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0);
    idleGap(3);

    for (int i = 0; i < 80; i++) begin
      bit co, ce;
      co = ($urandom % 4) != 0;
      ce = ($urandom % 4) != 0;
      runCycle(1'($urandom), 1'($urandom), 1'($urandom), co, ce,
               int'($urandom % 8), int'($urandom % 8), ($urandom % 8) == 0);
      idleGap(int'($urandom % 3));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule